// File: doc/BRIEF.md
# TLB Special-Register Access Unit

This block is the register-side front end of a software-managed translation buffer in a small soft processor core. The core issues one special-register access per cycle, a read or a write, with a 3-bit register number and an extended-access flag. The block decodes the access and checks it against the core's MMU configuration level and TLB-access setting. It then reads or updates an index register, a process-ID register, a zone-protection register, the per-entry tag RAM, or one of two entry RAMs. Accesses that are not allowed return zero or are dropped, and a one-cycle error pulse marks them.

The index register picks one of 256 entries. Register numbers 0 and 1 reach the low-word and high-word entry RAMs, and bit 0 of the register number chooses between them. A low-word entry is 64 bits wide. A normal access reaches its lower 32 bits and an extended access reaches its upper 32 bits. Reading the high word loads the process ID from the entry's tag. Writing the high word stores the current process ID as the entry's tag and emits a one-cycle invalidate carrying the entry index, so that an external translation cache can drop its copy.

Top module: `tlbacc_unit`

## Requirements
- R1: After reset, every entry RAM word, every tag, the index, the process ID and the zone register hold 0, and rd_valid, acc_err and inv_valid are low.
- R2: Register number 4 is the index register. A write keeps the low 8 bits of the data, a read returns them zero-extended, and later entry accesses use that entry.
- R3: Register numbers 0 (low word) and 1 (high word) select separate entry RAMs. A normal write stores 32 bits, and a read returns the stored word of the indexed entry.
- R4: An extended write to register 0 replaces only bits 63:32 of the low-word entry and keeps bits 31:0. An extended read of register 0 returns bits 63:32.
- R5: An extended access to any register other than 0 reads as 0, changes nothing, fires no invalidate and raises acc_err.
- R6: A legal read of register 1 loads the process ID (register 2, 8 bits) with the tag of the indexed entry.
- R7: A legal write of register 1 stores the process ID as the tag of the indexed entry. One cycle later, inv_valid is high for exactly one cycle with inv_index equal to the entry index.
- R8: If cfg_level is below 2 or cfg_tlb_acc is 0, every access reads 0, changes no state and raises acc_err.
- R9: Reads of registers 0, 1, 2 and 3 require cfg_tlb_acc bit 0 and otherwise return 0 with acc_err. Index reads do not need it.
- R10: A write to register 3 (zone, 32 bits) is rejected with acc_err when cfg_tlb_acc is 0 or 1, and is accepted when it is 2 or 3.
- R11: Register numbers 5 to 7 read as 0, are not written, and raise acc_err.
- R12: rd_valid and rd_data appear exactly one cycle after a read and never after a write. acc_err is a one-cycle pulse one cycle after the offending access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_ext | input | 1 | Extended access (upper half of a low-word entry) |
| acc_reg | input | 3 | Register number |
| acc_wdata | input | 32 | Write data |
| cfg_level | input | 2 | MMU configuration level |
| cfg_tlb_acc | input | 2 | TLB-access setting |
| rd_valid | output | 1 | Read data valid (one cycle after a read) |
| rd_data | output | 32 | Read data |
| acc_err | output | 1 | Illegal-access pulse |
| inv_valid | output | 1 | Entry invalidate pulse |
| inv_index | output | 8 | Index of the invalidated entry |

## Verification
The assertions assume that cfg_level and cfg_tlb_acc are stable for the cycle in which an access is sampled. They also assume that an access is one cycle of acc_valid, with no queueing, so each error or read result maps to the access one edge earlier. The stimulus changes all inputs only on falling edges, so every access lasts exactly one rising edge. It also changes the configuration only along with an access, and it drives every input to zero from time zero through reset, so the history the properties use is defined.

// File: rtl/tlbacc_pkg.sv
package tlbacc_pkg;

  localparam logic [2:0] REG_LO  = 3'd0;
  localparam logic [2:0] REG_HI  = 3'd1;
  localparam logic [2:0] REG_PID = 3'd2;
  localparam logic [2:0] REG_ZPR = 3'd3;
  localparam logic [2:0] REG_IDX = 3'd4;

  typedef enum logic [2:0] {
    SRC_ZERO, SRC_LO_L, SRC_LO_H, SRC_HI_L, SRC_PID, SRC_ZPR, SRC_IDX
  } src_e;

  typedef struct packed {
    logic err;
    logic ram_we;
    logic ram_sel;
    logic half;
    logic tag_we;
    logic pid_load;
    logic pid_we;
    logic zpr_we;
    logic idx_we;
    src_e src;
  } dec_t;

endpackage

// File: rtl/tlbacc_decode.sv
module tlbacc_decode
  import tlbacc_pkg::*;
(
  input  logic       valid,
  input  logic       write,
  input  logic       ext,
  input  logic [2:0] rsel,
  input  logic [1:0] level,
  input  logic [1:0] tlb_acc,
  output dec_t       dec
);

  logic enabled;
  logic rd_ok;

  assign enabled = (level >= 2'd2) && (tlb_acc != 2'd0);
  assign rd_ok   = tlb_acc[0];

  always_comb begin
    dec     = '0;
    dec.src = SRC_ZERO;
    if (valid) begin
      if (!enabled) begin
        dec.err = 1'b1;
      end else if (ext && rsel != REG_LO) begin
        dec.err = 1'b1;
      end else if (write) begin
        unique case (rsel)
          REG_LO, REG_HI: begin
            dec.ram_we  = 1'b1;
            dec.ram_sel = rsel[0];
            dec.half    = ext;
            dec.tag_we  = (rsel == REG_HI);
          end
          REG_PID: dec.pid_we = 1'b1;
          REG_ZPR: begin
            if (tlb_acc <= 2'd1) dec.err = 1'b1;
            else                 dec.zpr_we = 1'b1;
          end
          REG_IDX: dec.idx_we = 1'b1;
          default: dec.err = 1'b1;
        endcase
      end else begin
        unique case (rsel)
          REG_LO: begin
            if (rd_ok) dec.src = ext ? SRC_LO_H : SRC_LO_L;
            else       dec.err = 1'b1;
          end
          REG_HI: begin
            if (rd_ok) begin
              dec.src      = SRC_HI_L;
              dec.pid_load = 1'b1;
            end else begin
              dec.err = 1'b1;
            end
          end
          REG_PID: begin
            if (rd_ok) dec.src = SRC_PID;
            else       dec.err = 1'b1;
          end
          REG_ZPR: begin
            if (rd_ok) dec.src = SRC_ZPR;
            else       dec.err = 1'b1;
          end
          REG_IDX: dec.src = SRC_IDX;
          default: dec.err = 1'b1;
        endcase
      end
    end
  end

endmodule

// File: rtl/tlbacc_word_ram.sv
module tlbacc_word_ram #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[addr] <= wdata;
    end
  end

  assign rdata = mem[addr];

endmodule

// File: rtl/tlbacc_unit.sv
module tlbacc_unit
  import tlbacc_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int DW    = 32,
  parameter int TAG_W = 8,
  parameter int ZPR_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_valid,
  input  logic             acc_write,
  input  logic             acc_ext,
  input  logic [2:0]       acc_reg,
  input  logic [DW-1:0]    acc_wdata,
  input  logic [1:0]       cfg_level,
  input  logic [1:0]       cfg_tlb_acc,
  output logic             rd_valid,
  output logic [DW-1:0]    rd_data,
  output logic             acc_err,
  output logic             inv_valid,
  output logic [IDX_W-1:0] inv_index
);

  localparam int LO_HALVES = 2;

  dec_t dec;

  logic [IDX_W-1:0] idx_q;
  logic [TAG_W-1:0] pid_q;
  logic [ZPR_W-1:0] zpr_q;
  logic [DW-1:0]    lo_rd [LO_HALVES];
  logic [DW-1:0]    hi_rd;
  logic [TAG_W-1:0] tag_rd;
  logic [DW-1:0]    rmux;

  tlbacc_decode u_dec (
    .valid   (acc_valid),
    .write   (acc_write),
    .ext     (acc_ext),
    .rsel    (acc_reg),
    .level   (cfg_level),
    .tlb_acc (cfg_tlb_acc),
    .dec     (dec)
  );

  for (genvar h = 0; h < LO_HALVES; h++) begin : g_lo
    tlbacc_word_ram #(.AW(IDX_W), .DW(DW)) u_ram (
      .clk   (clk),
      .rst   (rst),
      .we    (dec.ram_we && !dec.ram_sel && (dec.half == h[0])),
      .addr  (idx_q),
      .wdata (acc_wdata),
      .rdata (lo_rd[h])
    );
  end

  tlbacc_word_ram #(.AW(IDX_W), .DW(DW)) u_hi_ram (
    .clk   (clk),
    .rst   (rst),
    .we    (dec.ram_we && dec.ram_sel),
    .addr  (idx_q),
    .wdata (acc_wdata),
    .rdata (hi_rd)
  );

  tlbacc_word_ram #(.AW(IDX_W), .DW(TAG_W)) u_tag_ram (
    .clk   (clk),
    .rst   (rst),
    .we    (dec.tag_we),
    .addr  (idx_q),
    .wdata (pid_q),
    .rdata (tag_rd)
  );

  always_comb begin
    unique case (dec.src)
      SRC_LO_L: rmux = lo_rd[0];
      SRC_LO_H: rmux = lo_rd[1];
      SRC_HI_L: rmux = hi_rd;
      SRC_PID:  rmux = DW'(pid_q);
      SRC_ZPR:  rmux = DW'(zpr_q);
      SRC_IDX:  rmux = DW'(idx_q);
      default:  rmux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q     <= '0;
      pid_q     <= '0;
      zpr_q     <= '0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
      acc_err   <= 1'b0;
      inv_valid <= 1'b0;
      inv_index <= '0;
    end else begin
      rd_valid  <= acc_valid && !acc_write;
      rd_data   <= rmux;
      acc_err   <= dec.err;
      inv_valid <= dec.tag_we;
      inv_index <= dec.tag_we ? idx_q : '0;
      if (dec.idx_we)        idx_q <= acc_wdata[IDX_W-1:0];
      if (dec.zpr_we)        zpr_q <= acc_wdata[ZPR_W-1:0];
      if (dec.pid_we)        pid_q <= acc_wdata[TAG_W-1:0];
      else if (dec.pid_load) pid_q <= tag_rd;
    end
  end

endmodule

// File: rtl/tlbacc_unit_chk.sv
module tlbacc_unit_chk #(
  parameter int IDX_W = 8,
  parameter int DW    = 32,
  parameter int TAG_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             acc_valid,
  input logic             acc_write,
  input logic             acc_ext,
  input logic [2:0]       acc_reg,
  input logic [1:0]       cfg_level,
  input logic [1:0]       cfg_tlb_acc,
  input logic             rd_valid,
  input logic [DW-1:0]    rd_data,
  input logic             acc_err,
  input logic             inv_valid,
  input logic [IDX_W-1:0] inv_index,
  input logic [IDX_W-1:0] idx_q,
  input logic [TAG_W-1:0] pid_q
);

  logic off;
  assign off = (cfg_level < 2'd2) || (cfg_tlb_acc == 2'd0);

  AST_RD_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_write) |=> rd_valid); // R12
  AST_RD_ONLY_FOR_READ: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(acc_valid && !acc_write)); // R12
  AST_OFF_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_write && off) |=> (rd_data == '0 && acc_err)); // R8
  AST_OFF_PID_KEPT: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && off) |=> $stable(pid_q)); // R8
  AST_EXT_ONLY_LO: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_ext && acc_reg != 3'd0) |=> (acc_err && !inv_valid)); // R5
  AST_UNKNOWN_REG: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_reg > 3'd4) |=> acc_err); // R11
  AST_ZPR_WR_LOCK: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_write && acc_reg == 3'd3 && cfg_tlb_acc <= 2'd1) |=> acc_err); // R10
  AST_INV_CAUSE: assert property (@(posedge clk) disable iff (rst)
    inv_valid |-> $past(acc_valid && acc_write && acc_reg == 3'd1 && !acc_ext && !off)); // R7
  AST_INV_INDEX: assert property (@(posedge clk) disable iff (rst)
    inv_valid |-> (inv_index == $past(idx_q))); // R7
  AST_IDX_KEPT: assert property (@(posedge clk) disable iff (rst)
    !(acc_valid && acc_write && acc_reg == 3'd4) |=> $stable(idx_q)); // R2

endmodule

bind tlbacc_unit tlbacc_unit_chk #(.IDX_W(IDX_W), .DW(DW), .TAG_W(TAG_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .acc_valid   (acc_valid),
  .acc_write   (acc_write),
  .acc_ext     (acc_ext),
  .acc_reg     (acc_reg),
  .cfg_level   (cfg_level),
  .cfg_tlb_acc (cfg_tlb_acc),
  .rd_valid    (rd_valid),
  .rd_data     (rd_data),
  .acc_err     (acc_err),
  .inv_valid   (inv_valid),
  .inv_index   (inv_index),
  .idx_q       (idx_q),
  .pid_q       (pid_q)
);

// File: tb/tb_tlbacc_unit.sv
module tb_tlbacc_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic        acc_ext = 1'b0;
  logic [2:0]  acc_reg = '0;
  logic [31:0] acc_wdata = '0;
  logic [1:0]  cfg_level = '0;
  logic [1:0]  cfg_tlb_acc = '0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic        acc_err;
  logic        inv_valid;
  logic [7:0]  inv_index;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  tlbacc_unit dut (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_ext(acc_ext), .acc_reg(acc_reg), .acc_wdata(acc_wdata),
    .cfg_level(cfg_level), .cfg_tlb_acc(cfg_tlb_acc), .rd_valid(rd_valid),
    .rd_data(rd_data), .acc_err(acc_err), .inv_valid(inv_valid), .inv_index(inv_index)
  );

  typedef struct packed {
    logic        wr;
    logic        ext;
    logic [2:0]  rg;
    logic [31:0] wd;
    logic [1:0]  lvl;
    logic [1:0]  acc;
    logic [31:0] exp_rd;
    logic        exp_err;
    logic        exp_inv;
    logic [7:0]  exp_idx;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 49;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b0,3'd4,32'h0,       2'd2,2'd3,32'h0,       1'b0,1'b0,8'h00,8'd1},  // R1 index reads 0
    '{1'b0,1'b0,3'd0,32'h0,       2'd2,2'd3,32'h0,       1'b0,1'b0,8'h00,8'd1},  // R1 entry reads 0
    '{1'b1,1'b0,3'd4,32'h105,     2'd2,2'd3,32'h0,       1'b0,1'b0,8'h00,8'd2},  // R2 index write
    '{1'b0,1'b0,3'd4,32'h0,       2'd2,2'd3,32'h5,       1'b0,1'b0,8'h00,8'd2},  // R2 low 8 bits kept
    '{1'b1,1'b0,3'd0,32'hAAAA0001,2'd2,2'd3,32'h0,       1'b0,1'b0,8'h00,8'd3},  // R3
    '{1'b1,1'b0,3'd2,32'h13C,     2'd2,2'd3,32'h0,       1'b0,1'b0,8'h00,8'd7},  // R7 PID setup
    '{1'b0,1'b0,3'd2,32'h0,       2'd2,2'd3,32'h3C,      1'b0,1'b0,8'h00,8'd7},  // R7
    '{1'b1,1'b0,3'd1,32'hBBBB0002,2'd2,2'd3,32'h0,       1'b0,1'b1,8'h05,8'd7},  // R7 invalidate
    '{1'b0,1'b0,3'd0,32'h0,       2'd2,2'd3,32'hAAAA0001,1'b0,1'b0,8'h00,8'd3},  // R3
    '{1'b0,1'b0,3'd1,32'h0,       2'd2,2'd3,32'hBBBB0002,1'b0,1'b0,8'h00,8'd3},  // R3
    '{1'b1,1'b1,3'd0,32'hCCCC0003,2'd2,2'd3,32'h0,       1'b0,1'b0,8'h00,8'd4},  // R4 ext write
    '{1'b0,1'b0,3'd0,32'h0,       2'd2,2'd3,32'hAAAA0001,1'b0,1'b0,8'h00,8'd4},  // R4 lower kept
    '{1'b0,1'b1,3'd0,32'h0,       2'd2,2'd3,32'hCCCC0003,1'b0,1'b0,8'h00,8'd4},  // R4 upper
    '{1'b1,1'b0,3'd2,32'h77,      2'd2,2'd3,32'h0,       1'b0,1'b0,8'h00,8'd6},  // R6 setup
    '{1'b0,1'b0,3'd1,32'h0,       2'd2,2'd3,32'hBBBB0002,1'b0,1'b0,8'h00,8'd6},  // R6 load
    '{1'b0,1'b0,3'd2,32'h0,       2'd2,2'd3,32'h3C,      1'b0,1'b0,8'h00,8'd6},  // R6 PID from tag
    '{1'b0,1'b1,3'd1,32'h0,       2'd2,2'd3,32'h0,       1'b1,1'b0,8'h00,8'd5},  // R5
    '{1'b1,1'b1,3'd1,32'hDEAD,    2'd2,2'd3,32'h0,       1'b1,1'b0,8'h00,8'd5},  // R5
    '{1'b0,1'b0,3'd1,32'h0,       2'd2,2'd3,32'hBBBB0002,1'b0,1'b0,8'h00,8'd5},  // R5 unchanged
    '{1'b0,1'b1,3'd2,32'h0,       2'd2,2'd3,32'h0,       1'b1,1'b0,8'h00,8'd5},  // R5
    '{1'b1,1'b0,3'd3,32'h1234,    2'd2,2'd1,32'h0,       1'b1,1'b0,8'h00,8'd10}, // R10 rejected
    '{1'b0,1'b0,3'd3,32'h0,       2'd2,2'd3,32'h0,       1'b0,1'b0,8'h00,8'd10}, // R10
    '{1'b1,1'b0,3'd3,32'h1234,    2'd2,2'd2,32'h0,       1'b0,1'b0,8'h00,8'd10}, // R10 accepted
    '{1'b0,1'b0,3'd3,32'h0,       2'd2,2'd2,32'h0,       1'b1,1'b0,8'h00,8'd9},  // R9
    '{1'b0,1'b0,3'd3,32'h0,       2'd2,2'd3,32'h1234,    1'b0,1'b0,8'h00,8'd10}, // R10
    '{1'b0,1'b0,3'd0,32'h0,       2'd2,2'd2,32'h0,       1'b1,1'b0,8'h00,8'd9},  // R9
    '{1'b0,1'b0,3'd1,32'h0,       2'd2,2'd2,32'h0,       1'b1,1'b0,8'h00,8'd9},  // R9
    '{1'b0,1'b0,3'd2,32'h0,       2'd2,2'd2,32'h0,       1'b1,1'b0,8'h00,8'd9},  // R9
    '{1'b0,1'b0,3'd4,32'h0,       2'd2,2'd2,32'h5,       1'b0,1'b0,8'h00,8'd9},  // R9 index read ok
    '{1'b1,1'b0,3'd0,32'h5555,    2'd1,2'd3,32'h0,       1'b1,1'b0,8'h00,8'd8},  // R8
    '{1'b0,1'b0,3'd0,32'h0,       2'd1,2'd3,32'h0,       1'b1,1'b0,8'h00,8'd8},  // R8
    '{1'b1,1'b0,3'd2,32'h99,      2'd2,2'd0,32'h0,       1'b1,1'b0,8'h00,8'd8},  // R8
    '{1'b1,1'b0,3'd1,32'h9999,    2'd0,2'd3,32'h0,       1'b1,1'b0,8'h00,8'd8},  // R8 no invalidate
    '{1'b0,1'b0,3'd0,32'h0,       2'd2,2'd3,32'hAAAA0001,1'b0,1'b0,8'h00,8'd8},  // R8
    '{1'b0,1'b0,3'd2,32'h0,       2'd2,2'd3,32'h3C,      1'b0,1'b0,8'h00,8'd8},  // R8
    '{1'b0,1'b0,3'd1,32'h0,       2'd2,2'd3,32'hBBBB0002,1'b0,1'b0,8'h00,8'd8},  // R8
    '{1'b0,1'b0,3'd6,32'h0,       2'd2,2'd3,32'h0,       1'b1,1'b0,8'h00,8'd11}, // R11
    '{1'b1,1'b0,3'd7,32'hFFFF,    2'd2,2'd3,32'h0,       1'b1,1'b0,8'h00,8'd11}, // R11
    '{1'b1,1'b0,3'd5,32'hFFFF,    2'd2,2'd3,32'h0,       1'b1,1'b0,8'h00,8'd11}, // R11
    '{1'b1,1'b0,3'd4,32'hFF,      2'd2,2'd3,32'h0,       1'b0,1'b0,8'h00,8'd2},  // R2 last entry
    '{1'b1,1'b0,3'd0,32'hFEED,    2'd2,2'd3,32'h0,       1'b0,1'b0,8'h00,8'd2},  // R2
    '{1'b0,1'b0,3'd0,32'h0,       2'd2,2'd3,32'hFEED,    1'b0,1'b0,8'h00,8'd2},  // R2
    '{1'b1,1'b0,3'd2,32'h5A,      2'd2,2'd3,32'h0,       1'b0,1'b0,8'h00,8'd7},  // R7
    '{1'b1,1'b0,3'd1,32'h0ABC,    2'd2,2'd3,32'h0,       1'b0,1'b1,8'hFF,8'd7},  // R7 index 255
    '{1'b1,1'b0,3'd2,32'h00,      2'd2,2'd3,32'h0,       1'b0,1'b0,8'h00,8'd6},  // R6
    '{1'b0,1'b0,3'd1,32'h0,       2'd2,2'd3,32'h0ABC,    1'b0,1'b0,8'h00,8'd6},  // R6
    '{1'b0,1'b0,3'd2,32'h0,       2'd2,2'd3,32'h5A,      1'b0,1'b0,8'h00,8'd6},  // R6
    '{1'b1,1'b0,3'd4,32'h05,      2'd2,2'd3,32'h0,       1'b0,1'b0,8'h00,8'd2},  // R2
    '{1'b0,1'b0,3'd0,32'h0,       2'd2,2'd3,32'hAAAA0001,1'b0,1'b0,8'h00,8'd2}   // R2 other entry intact
  };

  // Called at a falling edge; returns at the next falling edge after checking.
  task automatic run(input vec_t v);
    logic ok;
    acc_valid   = 1'b1;
    acc_write   = v.wr;
    acc_ext     = v.ext;
    acc_reg     = v.rg;
    acc_wdata   = v.wd;
    cfg_level   = v.lvl;
    cfg_tlb_acc = v.acc;
    @(negedge clk);
    acc_valid = 1'b0;
    ok = (rd_valid == !v.wr) && (acc_err == v.exp_err) && (inv_valid == v.exp_inv)
         && (v.wr || rd_data == v.exp_rd) && (!v.exp_inv || inv_index == v.exp_idx);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL R%0d reg=%0d wr=%0b: got rdv=%0b rd=%h err=%0b inv=%0b idx=%h, exp rdv=%0b rd=%h err=%0b inv=%0b idx=%h",
               v.req, v.rg, v.wr, rd_valid, rd_data, acc_err, inv_valid, inv_index,
               !v.wr, v.exp_rd, v.exp_err, v.exp_inv, v.exp_idx);
    end
  endtask

  task automatic check_idle(input string tag);
    n_chk++;
    if (rd_valid !== 1'b0 || acc_err !== 1'b0 || inv_valid !== 1'b0 || rd_data !== 32'h0) begin
      n_bad++;
      $display("FAIL %s idle outputs: got rdv=%0b err=%0b inv=%0b rd=%h, exp 0 0 0 0",
               tag, rd_valid, acc_err, inv_valid, rd_data);
    end
  endtask

  function automatic vec_t mk(input logic wr, input logic [2:0] rg, input logic [31:0] wd,
                              input logic [31:0] exp_rd, input logic [7:0] req);
    vec_t v;
    v = '{wr, 1'b0, rg, wd, 2'd2, 2'd3, exp_rd, 1'b0, 1'b0, 8'h00, req};
    return v;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R12 watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    check_idle("R1");
    for (int i = 0; i < NV; i++) run(VEC[i]);

    // R12: error pulse lasts one cycle
    run('{1'b0,1'b0,3'd7,32'h0,2'd2,2'd3,32'h0,1'b1,1'b0,8'h00,8'd12});
    @(negedge clk);
    check_idle("R12");

    // R1: reset in the middle of operation clears everything
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check_idle("R1");
    run(mk(1'b0, 3'd4, 32'h0, 32'h0, 8'd1));        // R1 index cleared
    run(mk(1'b1, 3'd4, 32'h5, 32'h0, 8'd1));
    run(mk(1'b0, 3'd0, 32'h0, 32'h0, 8'd1));        // R1 RAM cleared
    run(mk(1'b0, 3'd1, 32'h0, 32'h0, 8'd1));        // R1 high RAM cleared
    run(mk(1'b0, 3'd2, 32'h0, 32'h0, 8'd1));        // R1 PID cleared
    run(mk(1'b0, 3'd3, 32'h0, 32'h0, 8'd1));        // R1 zone cleared
    run('{1'b0,1'b1,3'd0,32'h0,2'd2,2'd3,32'h0,1'b0,1'b0,8'h00,8'd1}); // R1 upper half cleared

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule